// File: doc/BRIEF.md
# I2C Serial Clock Generator

This block produces the serial clock of an I2C master from the system clock. It drives the line in open-drain fashion: `scl_pull` high means the pad pulls the clock line low, and `scl_pull` low releases it so the bus pull-up can raise it. The block reads the actual line level back through `scl_in`. Each half-period count starts only once the line is seen to have changed level. Rise time, fall time and any device holding the line low therefore lengthen the period instead of shortening a phase.

The full-period division ratio m comes from a fixed set of values that are not powers of two. A 4-bit select code picks it. Each half of the period lasts m/2 system-clock cycles from the cycle in which the new line level is detected. Two one-cycle strobes pace the data path. One marks the middle of the low phase, where data may change. The other marks the cycle in which the line is seen high, where data is sampled. The line input passes through a parameterised synchroniser (`SYNC_STAGES` flops, default 2), so each phase also includes that latency.

Top module: `scl_clock_gen`

## Requirements
- R1: While reset is active, and in the cycle after any edge that samples `en` low, `scl_pull`, `chg_stb` and `smp_stb` are all 0.
- R2: With `clk_sel[3]` = 0, `clk_sel[2:0]` selects m: 0→88, 1→172, 2→344, 3→44, 4→48, 5→96, 6→24, 7→24.
- R3: With `clk_sel[3]` = 1, m is half the value R2 gives for the same `clk_sel[2:0]`, but never below 24 (so 44, 86, 172, 24, 24, 48, 24, 24).
- R4: Once the synchronised line reads low while the block pulls, pulling continues for m/2 cycles, counting the detection cycle, and then the line is released.
- R5: Once the synchronised line reads high after release, the line stays released for m/2 cycles, counting the detection cycle, and then pulling starts.
- R6: If the line stays low after release because another device holds it, no high-phase count and no `smp_stb` occur, and `scl_pull` stays 0 until the line reads high.
- R7: Enabling starts with a low phase: `scl_pull` rises in the cycle after the first edge that samples `en` high. Disabling releases the line at the next edge.
- R8: `chg_stb` is a one-cycle pulse in the low phase at count floor(m/4), where the low-level detection cycle is count 0.
- R9: `smp_stb` is a one-cycle pulse in the cycle the synchronised line is first seen high after release.
- R10: The select code is captured only at the edge where pulling begins. A change at any other time applies from the next low phase on.
- R11: With constant select and no stretching, the full period is m + tR + tF + 2·`SYNC_STAGES` cycles, where tR and tF are the bus rise and fall delays in cycles. Example: m = 88, tR = 4, tF = 1, two stages gives 97.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Run the clock; low releases the line |
| clk_sel | input | 4 | Ratio select; bit 3 halves the ratio |
| scl_in | input | 1 | Level read back from the clock line |
| scl_pull | output | 1 | 1 = pull the clock line low |
| chg_stb | output | 1 | Data-change strobe, middle of the low phase |
| smp_stb | output | 1 | Data-sample strobe, line seen high |

## Verification
The select-code capture and the start of a low phase share one edge. The bench changes the code at the negative edge right after a low phase has begun, which is the earliest moment a change is too late. The change passes only if the period in progress keeps the old ratio and the next period uses the new one. Clock stretching and the high-phase start are also made to meet. A held line is let go in mid-release, and the bench requires the sample strobe and the later pull to arrive at the exact cycles that the rise delay and synchroniser depth give.

// File: rtl/scl_gen_pkg.sv
`timescale 1ns/1ps
package scl_gen_pkg;

   // Phase encoding: bit 2 is the pull-low drive, so the output is one flop.
   typedef enum logic [2:0] {
      PH_IDLE    = 3'b000,
      PH_WAIT_HI = 3'b001,
      PH_HIGH    = 3'b010,
      PH_WAIT_LO = 3'b100,
      PH_LOW     = 3'b101
   } scl_phase_e;

   localparam int unsigned RATIO_FLOOR = 24;
   localparam int unsigned RATIO_MAX   = 344;
   localparam int unsigned SEL_W       = 4;
   localparam int unsigned SEL_CODES   = 1 << SEL_W;

   function automatic int unsigned base_ratio(input logic [2:0] idx);
      int unsigned r;
      case (idx)
         3'd0:    r = 88;
         3'd1:    r = 172;
         3'd2:    r = 344;
         3'd3:    r = 44;
         3'd4:    r = 48;
         3'd5:    r = 96;
         default: r = 24;
      endcase
      return r;
   endfunction

   function automatic int unsigned ratio_of(input logic [SEL_W-1:0] code);
      int unsigned r;
      r = base_ratio(code[2:0]);
      if (code[SEL_W-1]) r = ((r / 2) < RATIO_FLOOR) ? RATIO_FLOOR : (r / 2);
      return r;
   endfunction

endpackage

// File: rtl/scl_line_sync.sv
`timescale 1ns/1ps
module scl_line_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   generate
      if (STAGES == 0) begin : g_pass
         logic unused_clk_rst;
         assign unused_clk_rst = clk ^ rst_n;
         assign q = d;
      end else begin : g_chain
         logic [STAGES-1:0] sh;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sh <= '1;
            end else begin
               sh[0] <= d;
               for (int i = 1; i < int'(STAGES); i++) sh[i] <= sh[i-1];
            end
         end
         assign q = sh[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/scl_ratio_sel.sv
`timescale 1ns/1ps
module scl_ratio_sel
   import scl_gen_pkg::*;
#(
   parameter int unsigned CNT_W = 9
) (
   input  logic [SEL_W-1:0] sel,
   output logic [CNT_W-1:0] half
);

   logic [CNT_W-1:0] lut [SEL_CODES];

   generate
      for (genvar c = 0; c < int'(SEL_CODES); c++) begin : g_lut
         assign lut[c] = CNT_W'(ratio_of(SEL_W'(c)) / 2);
      end
   endgenerate

   assign half = lut[sel];

endmodule

// File: rtl/scl_phase_fsm.sv
`timescale 1ns/1ps
module scl_phase_fsm
   import scl_gen_pkg::*;
#(
   parameter int unsigned CNT_W = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             scl_s,
   input  logic [CNT_W-1:0] half_in,
   output logic             pull,
   output logic             chg_stb,
   output logic             smp_stb,
   output scl_phase_e       phase,
   output logic [CNT_W-1:0] half_q
);

   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

   scl_phase_e       st, st_nxt;
   logic [CNT_W-1:0] cnt, cnt_nxt;
   logic             half_ld;
   logic             at_last;

   assign at_last = (cnt == (half_q - CNT_ONE));

   always_comb begin
      st_nxt  = st;
      cnt_nxt = cnt;
      half_ld = 1'b0;
      if (!en) begin
         st_nxt  = PH_IDLE;
         cnt_nxt = '0;
      end else begin
         case (st)
            PH_IDLE: begin
               st_nxt  = PH_WAIT_LO;
               half_ld = 1'b1;
            end
            PH_WAIT_LO: begin
               if (!scl_s) begin
                  st_nxt  = PH_LOW;
                  cnt_nxt = CNT_ONE;
               end
            end
            PH_LOW: begin
               if (at_last) begin
                  st_nxt  = PH_WAIT_HI;
                  cnt_nxt = '0;
               end else begin
                  cnt_nxt = cnt + CNT_ONE;
               end
            end
            PH_WAIT_HI: begin
               if (scl_s) begin
                  st_nxt  = PH_HIGH;
                  cnt_nxt = CNT_ONE;
               end
            end
            PH_HIGH: begin
               if (at_last) begin
                  st_nxt  = PH_WAIT_LO;
                  cnt_nxt = '0;
                  half_ld = 1'b1;
               end else begin
                  cnt_nxt = cnt + CNT_ONE;
               end
            end
            default: begin
               st_nxt  = PH_IDLE;
               cnt_nxt = '0;
            end
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= PH_IDLE;
         cnt    <= '0;
         half_q <= CNT_W'(ratio_of('0) / 2);
      end else begin
         st  <= st_nxt;
         cnt <= cnt_nxt;
         if (half_ld) half_q <= half_in;
      end
   end

   assign pull    = st[2];
   assign chg_stb = (st == PH_LOW) && (cnt == (half_q >> 1));
   assign smp_stb = (st == PH_WAIT_HI) && scl_s;
   assign phase   = st;

endmodule

// File: rtl/scl_clock_gen.sv
`timescale 1ns/1ps
module scl_clock_gen
   import scl_gen_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned CNT_W       = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [SEL_W-1:0] clk_sel,
   input  logic             scl_in,
   output logic             scl_pull,
   output logic             chg_stb,
   output logic             smp_stb
);

   localparam int unsigned HALF_W_MIN = $clog2(RATIO_MAX / 2 + 1);

   generate
      if (CNT_W < HALF_W_MIN) begin : g_bad_cnt_w
         $error("CNT_W too narrow for the largest half-period");
      end
      if (SYNC_STAGES > 4) begin : g_bad_sync
         $error("SYNC_STAGES above 4 is not supported");
      end
   endgenerate

   logic             scl_s;
   logic [CNT_W-1:0] half_sel;
   logic [CNT_W-1:0] half_q;
   scl_phase_e       phase;

   scl_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (scl_in),
      .q     (scl_s)
   );

   scl_ratio_sel #(.CNT_W(CNT_W)) u_ratio (
      .sel  (clk_sel),
      .half (half_sel)
   );

   scl_phase_fsm #(.CNT_W(CNT_W)) u_fsm (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (en),
      .scl_s   (scl_s),
      .half_in (half_sel),
      .pull    (scl_pull),
      .chg_stb (chg_stb),
      .smp_stb (smp_stb),
      .phase   (phase),
      .half_q  (half_q)
   );

endmodule

// File: rtl/scl_clock_gen_chk.sv
`timescale 1ns/1ps
module scl_clock_gen_chk
   import scl_gen_pkg::*;
#(
   parameter int unsigned CNT_W = 9
) (
   input logic             clk,
   input logic             rst_n,
   input logic             en,
   input logic             scl_pull,
   input logic             chg_stb,
   input logic             smp_stb,
   input logic             scl_s,
   input scl_phase_e       phase,
   input logic [CNT_W-1:0] half_q
);

   localparam logic [CNT_W:0] RUN_MAX = '1;

   logic [CNT_W:0] lo_run, hi_run;
   logic [CNT_W:0] half_last;

   assign half_last = {1'b0, half_q} - 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_run <= '0;
         hi_run <= '0;
      end else begin
         if (!en || !(scl_pull && !scl_s)) lo_run <= '0;
         else if (lo_run != RUN_MAX)       lo_run <= lo_run + 1'b1;
         if (!en || phase == PH_IDLE || !(!scl_pull && scl_s)) hi_run <= '0;
         else if (hi_run != RUN_MAX)                           hi_run <= hi_run + 1'b1;
      end
   end

   a_r1_disable_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (!scl_pull && !chg_stb && !smp_stb));

   a_r2_half_legal: assert property (@(posedge clk) disable iff (!rst_n)
      half_q inside {CNT_W'(12), CNT_W'(22), CNT_W'(24), CNT_W'(43),
                     CNT_W'(44), CNT_W'(48), CNT_W'(86), CNT_W'(172)});

   a_r4_low_ends: assert property (@(posedge clk) disable iff (!rst_n)
      (en && scl_pull && !scl_s && lo_run == half_last) |=> !scl_pull);

   a_r4_low_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (en && scl_pull && !scl_s && lo_run < half_last) |=> scl_pull);

   a_r5_high_ends: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !scl_pull && scl_s && hi_run == half_last) |=> scl_pull);

   a_r6_stretch_wait: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_WAIT_HI && !scl_s) |=> !scl_pull);

   a_r8_chg_in_low: assert property (@(posedge clk) disable iff (!rst_n)
      chg_stb |-> (scl_pull && !scl_s));

   a_r8_chg_single: assert property (@(posedge clk) disable iff (!rst_n)
      chg_stb |=> !chg_stb);

   a_r9_smp_level: assert property (@(posedge clk) disable iff (!rst_n)
      smp_stb |-> (scl_s && !scl_pull));

   a_r9_smp_single: assert property (@(posedge clk) disable iff (!rst_n)
      smp_stb |=> !smp_stb);

   a_r10_sel_capture: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(half_q) |-> (phase == PH_WAIT_LO));

endmodule

bind scl_clock_gen scl_clock_gen_chk #(.CNT_W(CNT_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .en       (en),
   .scl_pull (scl_pull),
   .chg_stb  (chg_stb),
   .smp_stb  (smp_stb),
   .scl_s    (scl_s),
   .phase    (phase),
   .half_q   (half_q)
);

// File: tb/sim_scl_clock_gen.sv
`timescale 1ns/1ps
module sim_scl_clock_gen;

   localparam int SYNC   = 2;
   localparam int CNT_W  = 9;
   localparam int RISE_C = 4;
   localparam int FALL_C = 1;

   logic       clk   = 1'b0;
   logic       rst_n = 1'b0;
   logic       en    = 1'b0;
   logic       hold  = 1'b0;
   logic [3:0] sel   = 4'd0;
   logic       line  = 1'b1;
   int         dcnt  = 0;
   logic       pull, chg, smp;

   int nchk  = 0;
   int nfail = 0;
   bit done  = 1'b0;

   always #2.5 clk = ~clk;

   scl_clock_gen #(.SYNC_STAGES(SYNC), .CNT_W(CNT_W)) u0 (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (en),
      .clk_sel  (sel),
      .scl_in   (line),
      .scl_pull (pull),
      .chg_stb  (chg),
      .smp_stb  (smp)
   );

   // Bus: wired-AND of this master and an external holder, with edge delays.
   always @(posedge clk) begin
      if (line == !(pull || hold)) dcnt <= 0;
      else if (dcnt + 1 >= ((pull || hold) ? FALL_C : RISE_C)) begin
         line <= !(pull || hold);
         dcnt <= 0;
      end else dcnt <= dcnt + 1;
   end

   function automatic int ratio(input logic [3:0] code);
      int base [8] = '{88, 172, 344, 44, 48, 96, 24, 24};
      int r;
      r = base[code[2:0]];
      if (code[3]) r = (r / 2 < 24) ? 24 : r / 2;
      return r;
   endfunction

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // Behavioural reference: phase 0 off, 1 await low, 2 low count, 3 await high, 4 high count.
   int ph = 0, mc = 0, mh = 44;
   bit sq[$] = '{1'b1, 1'b1};
   bit s_prev = 1'b1, s_now = 1'b1;

   always @(posedge clk) begin
      if (!rst_n) begin
         ph = 0; mc = 0; mh = ratio(4'd0) / 2;
         sq = '{1'b1, 1'b1}; s_now = 1'b1;
      end else begin
         s_prev = sq[0];
         sq.push_back(line);
         void'(sq.pop_front());
         s_now = sq[0];
         if (!en) begin
            ph = 0; mc = 0;
         end else begin
            case (ph)
               0: begin ph = 1; mh = ratio(sel) / 2; end
               1: if (!s_prev) begin ph = 2; mc = 1; end
               2: if (mc == mh - 1) begin ph = 3; mc = 0; end else mc++;
               3: if (s_prev) begin ph = 4; mc = 1; end
               4: if (mc == mh - 1) begin ph = 1; mc = 0; mh = ratio(sel) / 2; end
                  else mc++;
               default: ph = 0;
            endcase
         end
      end
   end

   always @(negedge clk) begin
      if (!done) begin
         chk(pull == (ph == 1 || ph == 2), "R4 model pull", int'(pull), int'(ph == 1 || ph == 2));
         chk(chg == (ph == 2 && mc == mh / 2), "R8 model chg_stb", int'(chg),
             int'(ph == 2 && mc == mh / 2));
         chk(smp == (ph == 3 && s_now), "R9 model smp_stb", int'(smp), int'(ph == 3 && s_now));
      end
   end

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wait_rise();
      bit pv;
      pv = pull;
      forever begin
         @(negedge clk);
         if (pull && !pv) break;
         pv = pull;
      end
   endtask

   task automatic count_to_rise(output int c);
      bit pv;
      pv = pull;
      c = 0;
      forever begin
         @(negedge clk);
         c++;
         if (pull && !pv) break;
         pv = pull;
      end
   endtask

   task automatic measure(output int c);
      wait_rise();
      count_to_rise(c);
   endtask

   function automatic int period_of(input logic [3:0] code);
      return ratio(code) + RISE_C + FALL_C + 2 * SYNC;
   endfunction

   initial begin
      int p, c;
      tick(3);
      chk(!pull && !chg && !smp, "R1 in reset", int'({pull, chg, smp}), 0);
      rst_n = 1'b1;
      tick(5);
      chk(!pull && !chg && !smp, "R1 disabled", int'({pull, chg, smp}), 0);

      // R7: first phase is a low phase
      en = 1'b1;
      tick(1);
      chk(pull == 1'b1, "R7 pull after enable", int'(pull), 1);
      c = 0;
      do begin @(negedge clk); c++; end while (pull);
      chk(c == FALL_C + SYNC + 44, "R7 first low length", c, FALL_C + SYNC + 44);

      // R11: m = 88 with 4-cycle rise, 1-cycle fall
      measure(p);
      chk(p == 97, "R11 period m=88", p, 97);

      // R2 / R3: every select code
      for (int k = 0; k < 16; k++) begin
         sel = 4'(k);
         measure(p);
         if (k < 8) chk(p == period_of(4'(k)), "R2 period for code", p, period_of(4'(k)));
         else       chk(p == period_of(4'(k)), "R3 period for code", p, period_of(4'(k)));
      end

      // R10: change just after capture
      sel = 4'd0;
      measure(p);
      wait_rise();
      sel = 4'd2;
      count_to_rise(p);
      chk(p == period_of(4'd0), "R10 current period keeps old m", p, period_of(4'd0));
      count_to_rise(p);
      chk(p == period_of(4'd2), "R10 next period uses new m", p, period_of(4'd2));
      sel = 4'd0;
      measure(p);

      // R6 / R5: external device holds the line after release
      wait_rise();
      hold = 1'b1;
      do @(negedge clk); while (pull);
      for (int k = 0; k < 50; k++) begin
         @(negedge clk);
         chk(!pull && !smp, "R6 held line: no pull, no sample", int'({pull, smp}), 0);
      end
      hold = 1'b0;
      c = 0;
      do begin @(negedge clk); c++; end while (!smp);
      chk(c == RISE_C + SYNC, "R6 sample after hold ends", c, RISE_C + SYNC);
      c = 0;
      do begin @(negedge clk); c++; end while (!pull);
      chk(c == 44, "R5 high count length", c, 44);

      // R7: disable mid-phase and re-enable
      wait_rise();
      tick(10);
      en = 1'b0;
      tick(1);
      chk(!pull, "R7 release on disable", int'(pull), 0);
      tick(2);
      chk(!chg && !smp, "R1 strobes quiet while disabled", int'({chg, smp}), 0);
      tick(20);
      en = 1'b1;
      tick(1);
      chk(pull == 1'b1, "R7 pull on re-enable", int'(pull), 1);

      sel = 4'b1011;
      measure(p);
      chk(p == period_of(4'b1011), "R3 floor code period", p, period_of(4'b1011));

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         nchk++;
         nfail++;
         done = 1'b1;
         $display("FAIL watchdog (all requirements): actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
         $finish;
      end
   end

endmodule